// File: doc/BRIEF.md
# 8-bit Timer with Compare-Driven Waveform Pin

This block is an 8-bit up-counter that advances by one on each cycle where the count-enable tick is high. It has one compare register, and it compares that register with the count on every tick. A two-bit counting mode selects between two behaviours. In free-running mode the count wraps past its maximum. In clear-on-match mode the compare register acts as the top of the count. When the count reaches its maximum, a sticky overflow flag is set. When the count equals the compare register on a tick, a sticky match flag is set.

A two-bit pin-action field decides what a compare match does to the waveform pin: nothing, toggle, drive low or drive high. The action is applied only in the two non-PWM counting modes. A force command applies the action at once without a real match.

Software reaches the block through a one-cycle register write port with four addresses:
- address 0 loads the counter;
- address 1 loads the compare value;
- address 2 holds the control fields;
- address 3 is a command strobe that forces a compare or clears either flag.

The counter value, both flags and the pin are plain outputs.

Top module: `timer8_cmp`

## Requirements
- R1: After reset the count, compare value, both flags and the pin are 0, and the counting mode and pin action are both 0.
- R2: In counting modes 0, 1 and 3 (control bits [1:0]), each tick adds one to the count and 0xFF wraps to 0x00. A cycle with no tick and no counter write leaves the count unchanged.
- R3: In counting mode 2, a tick on which the count equals the compare value loads 0 into the count instead of incrementing it.
- R4: A tick on which the count is 0xFF sets the overflow flag in the same edge that makes the count 0. The flag stays set until a write to address 3 with bit 1 set clears it. A set and a clear in the same cycle leave the flag set.
- R5: A tick on which the count equals the compare value sets the match flag. A write to address 3 with bit 2 set clears it, and a set in the same cycle wins over the clear.
- R6: In modes 0 and 2, a compare match applies the pin action held in control bits [3:2]: 00 leaves the pin alone, 01 toggles it, 10 drives it to 0 and 11 drives it to 1.
- R7: Writing a new pin action does not change the pin. The new action is used from the first compare match (or force) after the write.
- R8: In modes 0 and 2, a write to address 3 with bit 0 set applies the current pin action at the next edge. It does not set the match flag and does not clear the count. A force and a match in the same cycle apply the action once.
- R9: In modes 1 and 3 the pin keeps its value through matches and forces.
- R10: A write to address 0 loads the count in any mode and takes priority over a tick in the same cycle. That tick then causes no increment, match or overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable for this cycle |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 count, 1 compare, 2 control, 3 command |
| wrData | input | 8 | Write data |
| cntVal | output | 8 | Current count |
| ovfFlag | output | 1 | Sticky overflow flag |
| cmpFlag | output | 1 | Sticky compare-match flag |
| wavePin | output | 1 | Waveform output pin |

## Verification
The properties assume that `tick`, `wrEn`, `wrAddr` and `wrData` are stable around the rising edge. They also assume that a write uses one address per cycle, so a counter load and a command can never arrive together. The bench changes every input on the falling edge only and issues one write per cycle. Its directed phases place writes next to matches and the wrap on purpose. The random phase mixes ticks with counter, compare, control and command writes under the same one-write rule.

// File: rtl/timer8_pkg.sv
package timer8_pkg;

  typedef enum logic [1:0] {
    CNT_FREE     = 2'd0,
    CNT_ALT1     = 2'd1,
    CNT_CLRMATCH = 2'd2,
    CNT_ALT3     = 2'd3
  } cntMode_e;

  typedef enum logic [1:0] {
    PIN_NONE   = 2'd0,
    PIN_TOGGLE = 2'd1,
    PIN_CLEAR  = 2'd2,
    PIN_SET    = 2'd3
  } pinAct_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic    loadCnt;
    logic    zeroCnt;
    logic    incCnt;
    logic    setOvf;
    logic    clrOvf;
    logic    setCmp;
    logic    clrCmp;
    logic    pinFire;
    pinAct_e pinAct;
  } dpStrobe_t;

endpackage

// File: rtl/timer8_ctrl.sv
module timer8_ctrl
  import timer8_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [W-1:0]  wrData,
  input  logic [W-1:0]  cntVal,
  output dpStrobe_t     strb,
  output logic [W-1:0]  cmpVal,
  output logic [1:0]    modeVal
);

  localparam logic [AW-1:0] ADDR_CNT  = AW'(0);
  localparam logic [AW-1:0] ADDR_CMP  = AW'(1);
  localparam logic [AW-1:0] ADDR_CTRL = AW'(2);
  localparam logic [AW-1:0] ADDR_CMD  = AW'(3);
  localparam int BIT_FORCE  = 0;
  localparam int BIT_CLROVF = 1;
  localparam int BIT_CLRCMP = 2;
  localparam logic [W-1:0] CNT_MAX = '1;

  cntMode_e     cntModeQ;
  pinAct_e      pinActQ;
  logic [W-1:0] cmpQ;

  logic cntWr, cmdWr, tickEff, isMatch, waveOk, forceReq;

  always_comb begin
    cntWr    = wrEn && (wrAddr == ADDR_CNT);
    cmdWr    = wrEn && (wrAddr == ADDR_CMD);
    tickEff  = tick && !cntWr;
    isMatch  = tickEff && (cntVal == cmpQ);
    waveOk   = (cntModeQ == CNT_FREE) || (cntModeQ == CNT_CLRMATCH);
    forceReq = cmdWr && wrData[BIT_FORCE];

    strb         = '0;
    strb.loadCnt = cntWr;
    strb.zeroCnt = isMatch && (cntModeQ == CNT_CLRMATCH);
    strb.incCnt  = tickEff;
    strb.setOvf  = tickEff && (cntVal == CNT_MAX);
    strb.clrOvf  = cmdWr && wrData[BIT_CLROVF];
    strb.setCmp  = isMatch;
    strb.clrCmp  = cmdWr && wrData[BIT_CLRCMP];
    strb.pinFire = waveOk && (isMatch || forceReq);
    strb.pinAct  = pinActQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntModeQ <= CNT_FREE;
      pinActQ  <= PIN_NONE;
      cmpQ     <= '0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_CMP) cmpQ <= wrData;
      if (wrAddr == ADDR_CTRL) begin
        cntModeQ <= cntMode_e'(wrData[1:0]);
        pinActQ  <= pinAct_e'(wrData[3:2]);
      end
    end
  end

  assign cmpVal  = cmpQ;
  assign modeVal = cntModeQ;

endmodule

// File: rtl/timer8_datapath.sv
module timer8_datapath
  import timer8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  dpStrobe_t    strb,
  input  logic [W-1:0] loadVal,
  output logic [W-1:0] cntQ,
  output logic         ovfQ,
  output logic         cmpQ,
  output logic         pinQ
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cntQ <= '0;
      ovfQ <= 1'b0;
      cmpQ <= 1'b0;
      pinQ <= 1'b0;
    end else begin
      if (strb.loadCnt)      cntQ <= loadVal;
      else if (strb.zeroCnt) cntQ <= '0;
      else if (strb.incCnt)  cntQ <= cntQ + 1'b1;

      if (strb.setOvf)      ovfQ <= 1'b1;
      else if (strb.clrOvf) ovfQ <= 1'b0;

      if (strb.setCmp)      cmpQ <= 1'b1;
      else if (strb.clrCmp) cmpQ <= 1'b0;

      if (strb.pinFire) begin
        unique case (strb.pinAct)
          PIN_TOGGLE: pinQ <= ~pinQ;
          PIN_CLEAR:  pinQ <= 1'b0;
          PIN_SET:    pinQ <= 1'b1;
          default:    pinQ <= pinQ;
        endcase
      end
    end
  end

endmodule

// File: rtl/timer8_cmp.sv
module timer8_cmp
  import timer8_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [W-1:0]  wrData,
  output logic [W-1:0]  cntVal,
  output logic          ovfFlag,
  output logic          cmpFlag,
  output logic          wavePin
);

  dpStrobe_t    strb;
  logic [W-1:0] cmpReg;
  logic [1:0]   modeReg;

  timer8_ctrl #(.W(W), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .cntVal(cntVal), .strb(strb), .cmpVal(cmpReg),
    .modeVal(modeReg)
  );

  timer8_datapath #(.W(W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .loadVal(wrData),
    .cntQ(cntVal), .ovfQ(ovfFlag), .cmpQ(cmpFlag), .pinQ(wavePin)
  );

endmodule

// File: rtl/timer8_cmp_chk.sv
module timer8_cmp_chk #(
  parameter int W  = 8,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          wrEn,
  input logic [AW-1:0] wrAddr,
  input logic [W-1:0]  wrData,
  input logic [W-1:0]  cntVal,
  input logic          ovfFlag,
  input logic          cmpFlag,
  input logic          wavePin,
  input logic [W-1:0]  cmpReg,
  input logic [1:0]    modeReg
);

  logic cntWr, clrOvfCmd, clrCmpCmd;
  assign cntWr     = wrEn && (wrAddr == AW'(0));
  assign clrOvfCmd = wrEn && (wrAddr == AW'(3)) && wrData[1];
  assign clrCmpCmd = wrEn && (wrAddr == AW'(3)) && wrData[2];

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cntWr && modeReg != 2'd2) |=> cntVal == W'($past(cntVal) + 1'b1));

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cntWr) |=> $stable(cntVal));

  // R3
  top_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cntWr && modeReg == 2'd2 && cntVal == cmpReg) |=> cntVal == '0);

  // R4
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cntWr && cntVal == '1) |=> ovfFlag);

  // R4
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfFlag && !clrOvfCmd) |=> ovfFlag);

  // R5
  cmp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cntWr && cntVal == cmpReg) |=> cmpFlag);

  // R5
  cmp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpFlag && !clrCmpCmd) |=> cmpFlag);

  // R9
  pwm_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    modeReg[0] |=> $stable(wavePin));

  // R10
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cntWr |=> cntVal == $past(wrData));

endmodule

bind timer8_cmp timer8_cmp_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .cntVal(cntVal), .ovfFlag(ovfFlag), .cmpFlag(cmpFlag),
  .wavePin(wavePin), .cmpReg(cmpReg), .modeReg(modeReg)
);

// File: tb/tb_timer8_cmp.sv
`timescale 1ns/1ps
module tb_timer8_cmp;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] cntVal;
  logic       ovfFlag, cmpFlag, wavePin;

  always #2.5 clk = ~clk;

  timer8_cmp dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .cntVal(cntVal), .ovfFlag(ovfFlag), .cmpFlag(cmpFlag),
    .wavePin(wavePin)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string curReq = "R1";

  // behavioural reference model
  int mCnt, mCmp, mMode, mAct, mOvf, mCmpF, mPin;

  always @(posedge clk) begin
    int nCnt, nPin;
    bit ld, mt, ovE, frc;
    if (!rst_n) begin
      mCnt = 0; mCmp = 0; mMode = 0; mAct = 0; mOvf = 0; mCmpF = 0; mPin = 0;
    end else begin
      ld  = wrEn && wrAddr == 0;
      mt  = tick && !ld && (mCnt == mCmp);
      ovE = tick && !ld && (mCnt == 255);
      frc = wrEn && wrAddr == 3 && wrData[0];
      if (ld) nCnt = wrData;
      else if (tick) nCnt = (mMode == 2 && mCnt == mCmp) ? 0 : (mCnt + 1) % 256;
      else nCnt = mCnt;
      nPin = mPin;
      if ((mMode == 0 || mMode == 2) && (mt || frc)) begin
        if (mAct == 1) nPin = 1 - mPin;
        else if (mAct == 2) nPin = 0;
        else if (mAct == 3) nPin = 1;
      end
      if (ovE) mOvf = 1;
      else if (wrEn && wrAddr == 3 && wrData[1]) mOvf = 0;
      if (mt) mCmpF = 1;
      else if (wrEn && wrAddr == 3 && wrData[2]) mCmpF = 0;
      if (wrEn && wrAddr == 1) mCmp = wrData;
      if (wrEn && wrAddr == 2) begin mMode = wrData[1:0]; mAct = wrData[3:2]; end
      mCnt = nCnt;
      mPin = nPin;
    end
  end

  task automatic expectEq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compareAll();
    expectEq(curReq, "cntVal", cntVal, mCnt);
    expectEq(curReq, "ovfFlag", ovfFlag, mOvf);
    expectEq(curReq, "cmpFlag", cmpFlag, mCmpF);
    expectEq(curReq, "wavePin", wavePin, mPin);
  endtask

  // called at a falling edge; applies inputs for one edge, compares after it
  task automatic cyc(bit t, bit en, int addr, int data);
    tick = t; wrEn = en; wrAddr = addr[1:0]; wrData = data[7:0];
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0; wrEn = 1'b0;
    compareAll();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0);
  endtask

  task automatic wr(int addr, int data);
    cyc(0, 1, addr, data);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    curReq = "R1";
    expectEq("R1", "cnt after reset", cntVal, 0);
    expectEq("R1", "ovf after reset", ovfFlag, 0);
    expectEq("R1", "cmp after reset", cmpFlag, 0);
    expectEq("R1", "pin after reset", wavePin, 0);

    // R2 free counting with gaps
    curReq = "R2";
    wr(1, 200);
    for (int i = 0; i < 8; i++) cyc(i % 3 != 0, 0, 0, 0);
    expectEq("R2", "cnt after 5 ticks", cntVal, 5);

    // R4 wrap and overflow
    curReq = "R4";
    wr(0, 8'hFA);
    ticks(6);
    expectEq("R4", "cnt wrapped", cntVal, 0);
    expectEq("R4", "ovf set on wrap", ovfFlag, 1);
    ticks(3);
    expectEq("R4", "ovf sticky", ovfFlag, 1);
    wr(3, 8'h02);
    expectEq("R4", "ovf cleared", ovfFlag, 0);
    wr(0, 8'hFF);
    cyc(1, 1, 3, 8'h02);
    expectEq("R4", "set beats clear", ovfFlag, 1);
    wr(3, 8'h02);

    // R3 clear on match with toggle
    curReq = "R3";
    wr(1, 5);
    wr(2, 8'h06);
    wr(0, 0);
    wr(3, 8'h04);
    ticks(6);
    expectEq("R3", "cnt cleared at top", cntVal, 0);
    expectEq("R6", "toggle on match", wavePin, 1);
    expectEq("R5", "match flag set", cmpFlag, 1);
    ticks(6);
    expectEq("R6", "second toggle", wavePin, 0);
    wr(3, 8'h04);
    expectEq("R5", "match flag cleared", cmpFlag, 0);

    // R5 set beats clear
    curReq = "R5";
    ticks(5);
    cyc(1, 1, 3, 8'h04);
    expectEq("R5", "set beats clear", cmpFlag, 1);

    // R6 set / clear / none actions
    curReq = "R6";
    wr(2, 8'h0E);
    ticks(6);
    expectEq("R6", "set action", wavePin, 1);
    wr(2, 8'h02);
    ticks(6);
    expectEq("R6", "none action", wavePin, 1);

    // R7 new action only at next match
    curReq = "R7";
    wr(2, 8'h0A);
    expectEq("R7", "pin unchanged by write", wavePin, 1);
    ticks(3);
    expectEq("R7", "pin unchanged before match", wavePin, 1);
    ticks(3);
    expectEq("R7", "clear at first match", wavePin, 0);

    // R8 force
    curReq = "R8";
    wr(2, 8'h06);
    wr(3, 8'h04);
    wr(0, 5);
    wr(3, 8'h01);
    expectEq("R8", "force toggles", wavePin, 1);
    expectEq("R8", "force no flag", cmpFlag, 0);
    expectEq("R8", "force no clear", cntVal, 5);
    cyc(1, 1, 3, 8'h01);
    expectEq("R8", "force+match once", wavePin, 0);
    expectEq("R8", "match cleared cnt", cntVal, 0);

    // R9 pwm modes hold pin
    curReq = "R9";
    wr(2, 8'h05);
    wr(3, 8'h01);
    expectEq("R9", "force ignored", wavePin, 0);
    ticks(10);
    expectEq("R9", "pin held over match", wavePin, 0);
    expectEq("R9", "no clear in mode 1", cntVal, 10);
    wr(2, 8'h0F);
    wr(0, 5);
    ticks(2);
    wr(3, 8'h01);
    expectEq("R9", "mode 3 pin held", wavePin, 0);

    // R10 counter write beats tick
    curReq = "R10";
    wr(2, 8'h06);
    wr(3, 8'h06);
    cyc(1, 1, 0, 5);
    expectEq("R10", "load beats tick", cntVal, 5);
    expectEq("R10", "no match on load", cmpFlag, 0);
    cyc(1, 1, 0, 8'hFF);
    wr(1, 8'hFF);
    cyc(1, 1, 0, 8'hFF);
    expectEq("R10", "no overflow on load", ovfFlag, 0);

    // mixed random traffic
    curReq = "R2";
    for (int i = 0; i < 400; i++) begin
      int r = $urandom_range(0, 19);
      bit t = $urandom_range(0, 3) != 0;
      if (r == 0) cyc(t, 1, 0, $urandom_range(0, 255));
      else if (r == 1) cyc(t, 1, 1, $urandom_range(0, 40));
      else if (r == 2) cyc(t, 1, 2, $urandom_range(0, 15));
      else if (r == 3) cyc(t, 1, 3, $urandom_range(0, 7));
      else cyc(t, 0, 0, 0);
    end

    finishRun();
  end

endmodule